// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for a four-beat synchronous burst in front of a memory array. A burst begins when either of two active-low start strobes is low at a rising clock edge. One strobe belongs to a processor and one to a controller. On that edge the external address is captured, and its two low bits become the base of the burst. On each later edge where the active-low advance input is low, the block moves to the next beat.

The order of the beats is chosen by a mode input, which is captured together with the address.

- **Linear order:** the two low bits count upward from the base and wrap modulo 4.
- **Interleaved order:** the two low bits are the base XORed with the beat count.

In both orders the upper address bits stay fixed, so a burst never leaves its four-word group.

The controller has two named states:

- **IDLE:** held from reset until the first strobe; the address output is zero.
- **BURST:** entered from IDLE by the transition START.

Inside BURST three transitions apply:

- **RESTART:** a strobe reloads the address and clears the beat.
- **STEP:** an advance increments the beat modulo 4.
- **HOLD:** with no strobe and no advance, everything keeps its value.

In IDLE the HOLD transition also covers an advance with no strobe, which is ignored.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low, and after it is released until the first strobe, addr_out is 0 and beat_idx is 0.
- R2: When start_cpu_n or start_ctl_n (or both) is 0 at a rising edge, addr_out equals addr_in and beat_idx equals 0 after that edge.
- R3: With interleave=0 captured at the last load, each rising edge with advance_n=0 and no strobe adds 1 modulo 4 to addr_out[1:0] and to beat_idx.
- R4: With interleave=1 captured at the last load, addr_out[1:0] equals the loaded addr_in[1:0] XOR beat_idx after each advance.
- R5: The upper bits addr_out[ADDR_W-1:2] change only on a strobe edge; addr_in is ignored on edges without a strobe.
- R6: On an edge with both strobes high and advance_n=1, addr_out and beat_idx keep their values.
- R7: A strobe and advance_n=0 at the same edge reload the address, and beat_idx becomes 0.
- R8: After beat 3, one further advance returns beat_idx to 0 and addr_out to the loaded address, staying within the same four-word group.
- R9: An advance before any strobe since reset has no effect; addr_out stays 0.
- R10: A change of interleave after a load has no effect on the order until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_cpu_n | input | 1 | Processor burst start strobe, active low |
| start_ctl_n | input | 1 | Controller burst start strobe, active low |
| advance_n | input | 1 | Beat advance, active low |
| interleave | input | 1 | Order select, captured on a strobe: 1 interleaved, 0 linear |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst word address |
| beat_idx | output | 2 | Beat count within the burst |

## Verification
Every result is due one rising edge after the edge that samples the stimulus: a load, a step, a hold or a reset release all show on addr_out and beat_idx directly after that edge. The bench changes inputs only on falling edges. Each vector spans exactly one rising edge, and the outputs are compared at the falling edge that follows. Reset is checked while it is held low, before any edge could mask it.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_t;

    function automatic logic [BEAT_W-1:0] order_low(
        input logic [BEAT_W-1:0] base,
        input logic [BEAT_W-1:0] beat,
        input logic              ilv
    );
        if (ilv) begin
            return base ^ beat;
        end
        return base + beat;
    endfunction

endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              adv,
    output burst_state_t      state,
    output logic [BEAT_W-1:0] beat
);

    burst_state_t      state_d;
    logic [BEAT_W-1:0] beat_d;

    // Transitions: START, RESTART, STEP, HOLD
    always_comb begin
        state_d = state;
        beat_d  = beat;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_BURST;
                    beat_d  = '0;
                end
            end
            ST_BURST: begin
                if (start) begin
                    beat_d = '0;
                end else if (adv) begin
                    beat_d = beat + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                beat_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            state <= state_d;
            beat  <= beat_d;
        end
    end

    // R3 / R8: a step moves the beat by one, wrapping past 3
    a_r3_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && !start && adv) |=> (beat == $past(beat) + 1'b1));

    // R6: hold keeps the beat
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !adv) |=> $stable(beat));

    // R7: a strobe wins over advance
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (beat == '0 && state == ST_BURST));

    // R9: advance alone never leaves IDLE
    a_r9_idle_stay: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> (state == ST_IDLE && beat == '0));

endmodule

// File: rtl/burst_base_capture.sv
module burst_base_capture #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ilv_in,
    output logic [ADDR_W-1:0] base_q,
    output logic              ilv_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ilv_q  <= 1'b0;
        end else if (load) begin
            base_q <= addr_in;
            ilv_q  <= ilv_in;
        end
    end

    // R5 / R10: captured address and order change only on a load
    a_r10_order_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(base_q) && $stable(ilv_q)));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cpu_n,
    input  logic              start_ctl_n,
    input  logic              advance_n,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BEAT_W-1:0] beat_idx
);

    logic              start;
    logic              adv;
    burst_state_t      state;
    logic [BEAT_W-1:0] beat;
    logic [ADDR_W-1:0] base_q;
    logic              ilv_q;

    assign start = !start_cpu_n || !start_ctl_n;
    assign adv   = !advance_n;

    burst_seq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .adv   (adv),
        .state (state),
        .beat  (beat)
    );

    burst_base_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .addr_in (addr_in),
        .ilv_in  (interleave),
        .base_q  (base_q),
        .ilv_q   (ilv_q)
    );

    // Output process
    always_comb begin
        beat_idx = beat;
        unique case (state)
            ST_IDLE:  addr_out = '0;
            ST_BURST: addr_out = {base_q[ADDR_W-1:BEAT_W],
                                  order_low(base_q[BEAT_W-1:0], beat, ilv_q)};
            default:  addr_out = '0;
        endcase
    end

    // R2: a strobe makes the next address the sampled one
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (addr_out == $past(addr_in) && beat_idx == '0));

    // R3: linear step adds one to the low bits
    a_r3_linear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && !start && adv && !ilv_q)
        |=> (addr_out[BEAT_W-1:0] == $past(addr_out[BEAT_W-1:0]) + 1'b1));

    // R4: interleaved step flips the low bits as the beat flips
    a_r4_interleave: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && !start && adv && ilv_q)
        |=> ((addr_out[BEAT_W-1:0] ^ $past(addr_out[BEAT_W-1:0]))
             == (beat_idx ^ $past(beat_idx))));

    // R5: upper bits fixed without a strobe
    a_r5_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && state == ST_BURST)
        |=> (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));

    // R1 / R9: no address before the first strobe
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (addr_out == '0 && beat_idx == '0));

endmodule

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;

    localparam int AW = 17;
    localparam int NV = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_n = 1'b1;
    logic          ctl_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          ilv = 1'b0;
    logic [AW-1:0] ain = '0;
    logic [AW-1:0] aout;
    logic [1:0]    bidx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_cpu_n (cpu_n),
        .start_ctl_n (ctl_n),
        .advance_n   (adv_n),
        .interleave  (ilv),
        .addr_in     (ain),
        .addr_out    (aout),
        .beat_idx    (bidx)
    );

    // {cpu_n, ctl_n, adv_n, ilv, addr_in, exp_addr, exp_beat}
    localparam logic [39:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b0, 1'b0, 17'h01234, 17'h00000, 2'd0},
        {1'b0, 1'b1, 1'b1, 1'b0, 17'h01235, 17'h01235, 2'd0},
        {1'b1, 1'b1, 1'b0, 1'b0, 17'h1FFFF, 17'h01236, 2'd1},
        {1'b1, 1'b1, 1'b0, 1'b1, 17'h0AAAA, 17'h01237, 2'd2},
        {1'b1, 1'b1, 1'b1, 1'b0, 17'h15555, 17'h01237, 2'd2},
        {1'b1, 1'b1, 1'b0, 1'b0, 17'h1FFFF, 17'h01234, 2'd3},
        {1'b1, 1'b1, 1'b0, 1'b0, 17'h1FFFF, 17'h01235, 2'd0},
        {1'b1, 1'b0, 1'b0, 1'b1, 17'h1ABCE, 17'h1ABCE, 2'd0},
        {1'b1, 1'b1, 1'b0, 1'b0, 17'h00000, 17'h1ABCF, 2'd1},
        {1'b1, 1'b1, 1'b0, 1'b0, 17'h00000, 17'h1ABCC, 2'd2},
        {1'b1, 1'b1, 1'b0, 1'b0, 17'h00000, 17'h1ABCD, 2'd3},
        {1'b1, 1'b1, 1'b0, 1'b0, 17'h00000, 17'h1ABCE, 2'd0},
        {1'b0, 1'b0, 1'b1, 1'b0, 17'h00003, 17'h00003, 2'd0},
        {1'b1, 1'b1, 1'b0, 1'b0, 17'h1FFFF, 17'h00000, 2'd1}
    };

    string tags [NV];

    task automatic check(input logic [AW-1:0] ea, input logic [1:0] eb, input string tag);
        checks++;
        if (aout !== ea) begin
            fails++;
            $display("FAIL %s addr_out actual=%h expected=%h", tag, aout, ea);
        end
        checks++;
        if (bidx !== eb) begin
            fails++;
            $display("FAIL %s beat_idx actual=%0d expected=%0d", tag, bidx, eb);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        tags[0]  = "R9 advance before strobe";
        tags[1]  = "R2 processor strobe load";
        tags[2]  = "R3 linear step 1 R5 addr_in ignored";
        tags[3]  = "R3 linear step 2";
        tags[4]  = "R6 hold";
        tags[5]  = "R3 linear wrap of low bits";
        tags[6]  = "R8 wrap to loaded address";
        tags[7]  = "R7 strobe beats advance";
        tags[8]  = "R4 interleave beat1 R10 mode change ignored";
        tags[9]  = "R4 interleave beat2";
        tags[10] = "R4 interleave beat3";
        tags[11] = "R8 interleave wrap";
        tags[12] = "R2 both strobes load";
        tags[13] = "R3 linear step from 3 R5 upper fixed";

        repeat (2) @(negedge clk);
        check('0, 2'd0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check('0, 2'd0, "R1 after release");

        for (int i = 0; i < NV; i++) begin
            cpu_n = VEC[i][39];
            ctl_n = VEC[i][38];
            adv_n = VEC[i][37];
            ilv   = VEC[i][36];
            ain   = VEC[i][35:19];
            @(posedge clk);
            @(negedge clk);
            check(VEC[i][18:2], VEC[i][1:0], tags[i]);
        end

        // Reset in the middle of a burst
        cpu_n = 1'b1; ctl_n = 1'b1; adv_n = 1'b1;
        rst_n = 1'b0;
        #1;
        check('0, 2'd0, "R1 reset mid burst");
        @(negedge clk);
        rst_n = 1'b1;
        adv_n = 1'b0;
        repeat (3) @(negedge clk);
        check('0, 2'd0, "R9 advance after reset");

        // Interleaved burst from odd base, strobe with advance held low
        ctl_n = 1'b0; ilv = 1'b1; ain = 17'h00F01;
        @(negedge clk);
        check(17'h00F01, 2'd0, "R7 load with advance low");
        ctl_n = 1'b1; ilv = 1'b0;
        @(negedge clk);
        check(17'h00F00, 2'd1, "R4 interleave 01^01");
        @(negedge clk);
        check(17'h00F03, 2'd2, "R4 interleave 01^10");
        @(negedge clk);
        check(17'h00F02, 2'd3, "R4 interleave 01^11");
        adv_n = 1'b1;
        @(negedge clk);
        check(17'h00F02, 2'd3, "R6 hold at last beat");
        adv_n = 1'b0;
        @(negedge clk);
        check(17'h00F01, 2'd0, "R8 interleave back to base");
        adv_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

endmodule